// File: doc/BRIEF.md
# I2C Target Controller with 7/10-bit Addressing

This block is the target (slave) side of an I2C bus, clocked from the system clock, which samples both bus lines. It never drives a line high. It pulls SCL or SDA low by raising the matching output-enable, and the pad logic outside turns each enable into an open-drain driver. Both lines pass through a short synchroniser chain. START and STOP are recognised on the synchronised copies, and all bit timing follows the edges of the synchronised SCL.

The host logic sets the target address and picks the address width with a mode input. In 10-bit mode the address is delivered in two bytes, and a read is entered through a repeated START. Bytes that a controller writes are assembled in a private shift register. Each complete byte is handed to a one-entry receive buffer, which the host empties with a read strobe. A one-cycle interrupt pulse marks each byte handed over. For reads, the target stretches SCL low and raises a transmit interrupt. The host then loads the transmit register and pulses a release control. The stretch happens after the read address is acknowledged and again after each transmitted byte that the controller acknowledges.

Top module: `i2c_target_ctl`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. The block changes its SDA enable only while SCL is low. After reset both enables are low, and the receive buffer is empty with no overflow.
- R2: When the mode input is 0, the first byte after a START is matched as address bits 7:1 against `cfg_addr[6:0]`. On a match the block drives ACK (SDA low) on the ninth clock. Otherwise it leaves SDA high (NACK) and ignores the bus until the next START.
- R3: A data byte that completes while the buffer is full and is not being read in that cycle is not stored. The block sets `rx_ovf`, answers NACK and keeps the earlier byte. A host read strobe clears both `rx_full` and `rx_ovf`.
- R4: In a write, each data byte completes on the rising edge of its eighth SCL pulse. If the buffer is free, the byte is copied to `rx_data`, `rx_full` is set, `irq_rx` pulses for exactly one cycle and the block ACKs.
- R5: A host read strobe in the same cycle as a data byte completes counts as a read that happens first. The new byte is accepted and acknowledged, `rx_full` stays set, and `rx_ovf` stays clear.
- R6: After it acknowledges a read address (R/W bit 1), the block holds SCL low from the end of the ACK clock and pulses `irq_tx` once. It keeps SCL held for as long as `rel_set` is not pulsed.
- R7: After `rel_set`, the byte last written with `tx_load` is shifted out MSB first, one bit per SCL low phase. If the controller acknowledges it, SCL is held again and `irq_tx` pulses again.
- R8: If the controller answers NACK to a transmitted byte, the block releases SDA and SCL and drives neither line until the next START.
- R9: When the mode input is 1, a write starts with the header 11110, `cfg_addr[9:8]`, R/W=0, followed by a byte equal to `cfg_addr[7:0]`. Both bytes are acknowledged. A wrong second byte is answered with NACK. A 7-bit style address is answered with NACK.
- R10: In 10-bit mode, a header with R/W=1 is acknowledged, and starts a read as in R6, only if it comes in a repeated START after a full 10-bit address match in the same transfer. Otherwise it gets NACK, and a STOP cancels the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level as seen at the pad |
| sda_i | input | 1 | SDA line level as seen at the pad |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_addr | input | 10 | Target address; bits 6:0 used in 7-bit mode |
| cfg_ten_bit | input | 1 | 1 selects 10-bit address matching |
| tx_data | input | 8 | Byte to load into the transmit register |
| tx_load | input | 1 | Writes `tx_data` into the transmit register |
| rel_set | input | 1 | Pulse that ends an SCL hold and starts transmitting |
| rx_rd | input | 1 | Host read strobe for the receive buffer |
| rx_data | output | 8 | Receive buffer contents |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| rx_ovf | output | 1 | A byte was refused because the buffer was full |
| irq_rx | output | 1 | One-cycle pulse when a byte enters the buffer |
| irq_tx | output | 1 | One-cycle pulse when SCL hold begins for a read |

## Verification
Two events can land in the same clock: the host read strobe that empties the buffer, and the completion of a new byte on the eighth SCL rise. To make them coincide, the bench counts the synchroniser and edge-detector latency from the moment it raises SCL, and places `rx_rd` on the exact edge where the byte completes. It then judges the outcome against R5. The controller must see ACK, the buffer must hold the new byte, and the overflow flag must stay clear. A separate run without the strobe must produce the opposite result on all three.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [4:0] HDR10_TAG = 5'b11110;

  typedef enum logic [2:0] {
    S_IDLE, S_RXB, S_ACKW, S_ACK, S_HOLD, S_REL, S_TXB, S_TACK
  } tgt_st_t;

  typedef enum logic [1:0] {PH_A1, PH_A2, PH_DAT} tgt_ph_t;

  // 7-bit match: address in bits 7:1, R/W in bit 0
  function automatic logic addr7_hit(input logic [BYTE_W-1:0] b,
                                     input logic [ADDR_W-1:0] a);
    return b[7:1] == a[6:0];
  endfunction

  // 10-bit header: 11110, A9:A8, R/W
  function automatic logic hdr10_hit(input logic [BYTE_W-1:0] b,
                                     input logic [ADDR_W-1:0] a);
    return (b[7:3] == HDR10_TAG) && (b[2:1] == a[9:8]);
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rx_buffer.sv
module i2c_rx_buffer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         rd,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         ovf,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      full <= 1'b0;
      ovf  <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (rd) begin
        full <= 1'b0;
        ovf  <= 1'b0;
      end
      if (load) begin
        if (!full || rd) begin
          dout <= din;
          full <= 1'b1;
          irq  <= 1'b1;
        end else begin
          ovf <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_target_ctl.sv
module i2c_target_ctl
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_ten_bit,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_load,
  input  logic              rel_set,
  input  logic              rx_rd,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_ovf,
  output logic              irq_rx,
  output logic              irq_tx
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [1:0] line_s;
  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;

  i2c_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  i2c_cond_detect u_det (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c)
  );

  tgt_st_t           st;
  tgt_ph_t           ph, ph_n;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh, sh_next, tx_reg;
  logic ack_q, go_rd, mack, ten_armed;
  logic scl_oe_q, sda_oe_q, irq_tx_q;
  logic ack_c, rd_c, armed_n;
  logic byte_done, load_req;

  assign sh_next   = {sh[BYTE_W-2:0], sda_s};
  assign byte_done = (st == S_RXB) && scl_rise && (cnt == LAST_BIT)
                     && !start_c && !stop_c;
  assign load_req  = byte_done && (ph == PH_DAT);

  // acknowledge and phase decision for the byte that completes now
  always_comb begin
    ack_c   = 1'b0;
    rd_c    = 1'b0;
    ph_n    = ph;
    armed_n = ten_armed;
    case (ph)
      PH_A1: begin
        armed_n = 1'b0;
        if (!cfg_ten_bit) begin
          ack_c = addr7_hit(sh_next, cfg_addr);
          rd_c  = sh_next[0];
          ph_n  = PH_DAT;
        end else if (hdr10_hit(sh_next, cfg_addr)) begin
          if (sh_next[0]) begin
            ack_c   = ten_armed;
            rd_c    = 1'b1;
            armed_n = ten_armed;
            ph_n    = PH_DAT;
          end else begin
            ack_c = 1'b1;
            ph_n  = PH_A2;
          end
        end
      end
      PH_A2: begin
        ack_c   = (sh_next == cfg_addr[7:0]);
        armed_n = ack_c;
        ph_n    = PH_DAT;
      end
      default: ack_c = !(rx_full && !rx_rd);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_reg <= '0;
    else if (tx_load) tx_reg <= tx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_A1; cnt <= '0; sh <= '0;
      ack_q <= 1'b0; go_rd <= 1'b0; mack <= 1'b0; ten_armed <= 1'b0;
      scl_oe_q <= 1'b0; sda_oe_q <= 1'b0; irq_tx_q <= 1'b0;
    end else begin
      irq_tx_q <= 1'b0;
      if (stop_c) begin
        st <= S_IDLE; sda_oe_q <= 1'b0; scl_oe_q <= 1'b0; ten_armed <= 1'b0;
      end else if (start_c) begin
        st <= S_RXB; ph <= PH_A1; cnt <= '0; sda_oe_q <= 1'b0;
      end else begin
        case (st)
          S_RXB: if (scl_rise) begin
            sh  <= sh_next;
            cnt <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              cnt <= '0; st <= S_ACKW; ack_q <= ack_c; go_rd <= rd_c;
              ph <= ph_n; ten_armed <= armed_n;
            end
          end
          S_ACKW: if (scl_fall) begin
            sda_oe_q <= ack_q;
            st       <= ack_q ? S_ACK : S_IDLE;
          end
          S_ACK: if (scl_fall) begin
            sda_oe_q <= 1'b0;
            if (go_rd) begin
              st <= S_HOLD; scl_oe_q <= 1'b1; irq_tx_q <= 1'b1;
            end else begin
              st <= S_RXB;
            end
          end
          S_HOLD: if (rel_set) begin
            sh <= tx_reg; sda_oe_q <= ~tx_reg[BYTE_W-1]; st <= S_REL;
          end
          S_REL: begin
            scl_oe_q <= 1'b0; cnt <= '0; st <= S_TXB;
          end
          S_TXB: if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              sda_oe_q <= 1'b0; st <= S_TACK;
            end else begin
              sh       <= {sh[BYTE_W-2:0], 1'b0};
              sda_oe_q <= ~sh[BYTE_W-2];
              cnt      <= cnt + 1'b1;
            end
          end
          S_TACK: begin
            if (scl_rise) mack <= ~sda_s;
            if (scl_fall) begin
              if (mack) begin
                st <= S_HOLD; scl_oe_q <= 1'b1; irq_tx_q <= 1'b1;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  i2c_rx_buffer #(.W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .load(load_req), .din(sh_next), .rd(rx_rd),
    .dout(rx_data), .full(rx_full), .ovf(rx_ovf), .irq(irq_rx)
  );

  assign scl_oe = scl_oe_q;
  assign sda_oe = sda_oe_q;
  assign irq_tx = irq_tx_q;
endmodule

// File: rtl/i2c_target_ctl_chk.sv
module i2c_target_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       scl_oe,
  input logic       irq_rx,
  input logic       irq_tx,
  input logic       rel_set,
  input logic       load_req,
  input logic       rx_rd,
  input logic       rx_full,
  input logic       rx_ovf,
  input logic [7:0] rx_data
);
  p_sda_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && rx_full && !rx_rd) |=> (rx_ovf && $stable(rx_data)));

  p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |=> !irq_rx);

  p_overlap_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && rx_full && rx_rd) |=> (rx_full && !rx_ovf && irq_rx));

  p_hold_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && !rel_set && !$past(rel_set)) |=> scl_oe);

  p_txirq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> scl_oe);
endmodule

bind i2c_target_ctl i2c_target_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .scl_oe(scl_oe),
  .irq_rx(irq_rx), .irq_tx(irq_tx), .rel_set(rel_set), .load_req(load_req),
  .rx_rd(rx_rd), .rx_full(rx_full), .rx_ovf(rx_ovf), .rx_data(rx_data)
);

// File: tb/sim_i2c_target_ctl.sv
`timescale 1ns/1ps
module sim_i2c_target_ctl;
  localparam int H = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe;
  logic [9:0] cfg_addr = 10'h2A5;
  logic cfg_ten_bit = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_load = 1'b0, rel_set = 1'b0, rx_rd = 1'b0;
  logic [7:0] rx_data;
  logic rx_full, rx_ovf, irq_rx, irq_tx;
  wire scl_ln = m_scl & ~scl_oe;
  wire sda_ln = m_sda & ~sda_oe;

  i2c_target_ctl u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_ln), .sda_i(sda_ln),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_addr(cfg_addr),
    .cfg_ten_bit(cfg_ten_bit), .tx_data(tx_data), .tx_load(tx_load),
    .rel_set(rel_set), .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full),
    .rx_ovf(rx_ovf), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  int n_chk = 0, n_err = 0, n_irq_rx = 0, n_irq_tx = 0;
  bit done = 1'b0;

  // behavioural model of the host-visible receive side
  logic [7:0] m_data = 8'h00;
  bit m_full = 1'b0, m_ovf = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock monitors: bus legality and receive-side model compare
  logic p_oe = 1'b0, p_scl = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe != p_oe && scl_ln && p_scl)
        chk(1'b0, "R1 sda change with scl high", sda_oe, p_oe);
      if (!tb_busy && (rx_full != m_full || rx_ovf != m_ovf || (m_full && rx_data != m_data)))
        chk(1'b0, "R4 model compare", {rx_full, rx_ovf, rx_data}, {m_full, m_ovf, m_data});
    end
    p_oe  = sda_oe;
    p_scl = scl_ln;
  end
  bit tb_busy = 1'b1;

  always @(posedge clk) begin
    if (irq_rx) n_irq_rx++;
    if (irq_tx) n_irq_tx++;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, input bit rdh, output logic smp);
    idle(2);
    m_sda = b;
    idle(H);
    m_scl = 1'b1;
    #1;
    while (!scl_ln) begin
      @(negedge clk);
      #1;
    end
    smp = 1'b1;
    for (int i = 0; i < H; i++) begin
      @(negedge clk);
      rx_rd = (rdh && i == 1);
      if (i == H / 2) smp = sda_ln;
    end
    rx_rd = 1'b0;
    m_scl = 1'b0;
  endtask

  task automatic bus_start();
    idle(2);
    m_sda = 1'b1;
    idle(H);
    m_scl = 1'b1;
    idle(H);
    m_sda = 1'b0;
    idle(H);
    m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    idle(2);
    m_sda = 1'b0;
    idle(H);
    m_scl = 1'b1;
    idle(H);
    m_sda = 1'b1;
    idle(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit rd_last, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], rd_last && i == 0, s);
    clk_bit(1'b1, 1'b0, s);
    acked = !s;
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] r);
    logic s;
    r = 8'h00;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, 1'b0, s);
      r = {r[6:0], s};
    end
    clk_bit(!give_ack, 1'b0, s);
  endtask

  task automatic host_read(output logic [7:0] d);
    @(negedge clk);
    d = rx_data;
    rx_rd = 1'b1;
    m_full = 1'b0;
    m_ovf = 1'b0;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic host_send(input logic [7:0] b);
    @(negedge clk);
    tx_data = b;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    rel_set = 1'b1;
    @(negedge clk);
    rel_set = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    bit a;
    int irx, itx;
    logic [7:0] r;
    idle(3);
    // R1: reset state
    chk(scl_oe == 0 && sda_oe == 0, "R1 reset enables", {scl_oe, sda_oe}, 0);
    chk(rx_full == 0 && rx_ovf == 0, "R1 reset buffer", {rx_full, rx_ovf}, 0);
    rst_n = 1'b1;
    idle(4);
    tb_busy = 1'b0;

    // R2/R4: 7-bit write (address 0x25 -> byte 0x4A)
    irx = n_irq_rx;
    bus_start();
    send_byte(8'h4A, 0, a);
    chk(a, "R2 address ack", a, 1);
    tb_busy = 1'b1;
    send_byte(8'h3C, 0, a);
    m_full = 1; m_data = 8'h3C;
    tb_busy = 1'b0;
    chk(a, "R4 data ack", a, 1);
    bus_stop();
    chk(rx_full && rx_data == 8'h3C, "R4 buffered byte", rx_data, 8'h3C);
    chk(n_irq_rx == irx + 1, "R4 irq_rx count", n_irq_rx - irx, 1);

    // R3: overflow while full
    bus_start();
    send_byte(8'h4A, 0, a);
    tb_busy = 1'b1;
    send_byte(8'h77, 0, a);
    m_ovf = 1;
    tb_busy = 1'b0;
    chk(!a, "R3 overflow nack", a, 0);
    bus_stop();
    chk(rx_ovf && rx_data == 8'h3C, "R3 kept byte", rx_data, 8'h3C);
    tb_busy = 1'b1;
    host_read(r);
    tb_busy = 1'b0;
    idle(2);
    chk(!rx_full && !rx_ovf, "R3 read clears", {rx_full, rx_ovf}, 0);

    // R2: wrong address ignored
    irx = n_irq_rx;
    bus_start();
    send_byte(8'h50, 0, a);
    chk(!a, "R2 wrong address nack", a, 0);
    send_byte(8'h11, 0, a);
    chk(!a, "R2 ignored data nack", a, 0);
    bus_stop();
    chk(!rx_full && n_irq_rx == irx, "R2 no receive", rx_full, 0);

    // R5: read strobe in the completion cycle
    bus_start();
    send_byte(8'h4A, 0, a);
    tb_busy = 1'b1;
    send_byte(8'h81, 0, a);
    send_byte(8'h42, 1, a);
    m_full = 1; m_ovf = 0; m_data = 8'h42;
    idle(2);
    tb_busy = 1'b0;
    chk(a, "R5 overlap ack", a, 1);
    chk(rx_full && !rx_ovf && rx_data == 8'h42, "R5 overlap data", rx_data, 8'h42);
    bus_stop();
    tb_busy = 1'b1;
    host_read(r);
    tb_busy = 1'b0;

    // R6/R7/R8: 7-bit read
    itx = n_irq_tx;
    bus_start();
    send_byte(8'h4B, 0, a);
    chk(a, "R6 read address ack", a, 1);
    idle(H);
    chk(scl_oe == 1 && n_irq_tx == itx + 1, "R6 hold after address", scl_oe, 1);
    idle(40);
    chk(scl_oe == 1, "R6 hold without release", scl_oe, 1);
    host_send(8'hA6);
    get_byte(1, r);
    chk(r == 8'hA6, "R7 first byte", r, 8'hA6);
    idle(H);
    chk(scl_oe == 1 && n_irq_tx == itx + 2, "R7 hold after master ack", n_irq_tx - itx, 2);
    host_send(8'h5D);
    get_byte(0, r);
    chk(r == 8'h5D, "R7 second byte", r, 8'h5D);
    idle(H);
    chk(scl_oe == 0 && sda_oe == 0, "R8 released after nack", {scl_oe, sda_oe}, 0);
    get_byte(0, r);
    chk(r == 8'hFF, "R8 silent until start", r, 8'hFF);
    bus_stop();

    // R9/R10: 10-bit write then repeated-start read (header 0xF4/0xF5, low 0xA5)
    cfg_ten_bit = 1'b1;
    bus_start();
    send_byte(8'hF4, 0, a);
    chk(a, "R9 header ack", a, 1);
    send_byte(8'hA5, 0, a);
    chk(a, "R9 low byte ack", a, 1);
    tb_busy = 1'b1;
    send_byte(8'hC3, 0, a);
    m_full = 1; m_data = 8'hC3;
    tb_busy = 1'b0;
    chk(a && rx_data == 8'hC3, "R9 data", rx_data, 8'hC3);
    bus_start();
    send_byte(8'hF5, 0, a);
    chk(a, "R10 read header ack", a, 1);
    idle(H);
    chk(scl_oe == 1, "R10 hold", scl_oe, 1);
    host_send(8'h9E);
    get_byte(0, r);
    chk(r == 8'h9E, "R10 read byte", r, 8'h9E);
    bus_stop();
    tb_busy = 1'b1;
    host_read(r);
    tb_busy = 1'b0;

    // R9: wrong low byte
    bus_start();
    send_byte(8'hF4, 0, a);
    send_byte(8'hA4, 0, a);
    chk(!a, "R9 wrong low byte nack", a, 0);
    bus_stop();

    // R10: read header after STOP is refused
    bus_start();
    send_byte(8'hF5, 0, a);
    chk(!a, "R10 unarmed read nack", a, 0);
    bus_stop();

    // R9: 7-bit style address refused in 10-bit mode
    bus_start();
    send_byte(8'h4A, 0, a);
    chk(!a, "R9 7-bit address in 10-bit mode", a, 0);
    bus_stop();

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule